// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the management registers of a 100BASE-X physical-layer device. A host reaches it through a simple bus with a one-cycle handshake. When cycle and strobe are both high at a clock edge, the register at the 5-bit address is read or written. The block answers on the next cycle with a single acknowledge pulse, or with an error pulse if nothing lives at that address. Serial management framing, the coding sublayers and autonegotiation sit outside this block.

The control register drives the loopback, power-down, isolate and collision-test outputs. A vendor test register drives the descrambler-test and link-monitor-test outputs. A status register reports the fixed 100BASE-X abilities and a link indication that latches low. The two identifier registers read as zero. Five 15-bit event counters saturate instead of wrapping and clear when read. They count negative wraparound, positive wraparound, link drops, false carrier and symbol errors.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the control register (address 0) reads 0x2400. Bit 13 (speed select) always reads 1, whatever is written to it.
- R2: Control bits 14 (loopback), 11 (power-down), 10 (isolate) and 7 (collision test) are read/write, and each drives its own output, which changes on the clock edge that accepts the write. Bit 8 (duplex) is read/write and drives no output. All other control bits read 0.
- R3: A write with control bit 15 set puts the control register back to 0x2400, whatever the other written bits are. Bit 15 always reads 0.
- R4: The status register (address 1) ignores writes. It reads bit 14 and bit 13 (100BASE-X full and half duplex) as 1, bit 0 (extended capability) as 1, bit 2 as the link status, and every other bit as 0. The identifier registers (addresses 2 and 3) read 0x0000 and ignore writes.
- R5: Status bit 2 latches low. It reads 0 if the link input is low at the read, or was low on any clock edge since the previous status read. A status read re-arms the latch from the link input sampled at that read.
- R6: Only addresses 0, 1, 2, 3, 16, 17, 18, 19, 21 and 30 are implemented. A read or write to any other address is answered with err instead of ack and changes no state.
- R7: The counters sit at address 16 (negative wraparound), 17 (positive wraparound), 18 (link drop), 19 (false carrier) and 21 (symbol error). Each is 15 bits wide, reads with bit 15 = 0, and stops at 0x7fff. A write loads the low 15 bits of the write data.
- R8: Reading a counter returns its value before the read and clears it. If an event is counted on the same edge as the read, the counter restarts at 1.
- R9: The link-drop counter increments once for each clock edge where the link input is seen falling from 1 to 0. The other four counters increment on every clock edge where their event input is high.
- R10: The vendor register (address 30) has read/write bit 15, which drives the descrambler-test output, and bit 14, which drives the link-monitor-test output. Both reset to 0, and its other bits read 0.
- R11: Each edge with cycle and strobe high produces exactly one ack or err pulse in the next cycle. Read data is valid in that cycle and is zero in all other cycles, on writes and on errors. With cycle low, strobe produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Access strobe, one access per sampled edge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with ack |
| bus_ack | output | 1 | Access done |
| bus_err | output | 1 | Access to an unimplemented address |
| link_up | input | 1 | Current link indication |
| neg_wrap_evt | input | 1 | Negative wraparound event |
| pos_wrap_evt | input | 1 | Positive wraparound event |
| false_carrier_evt | input | 1 | False carrier event |
| symbol_err_evt | input | 1 | Symbol error event |
| loopback_o | output | 1 | Loopback enable |
| power_down_o | output | 1 | Power-down request |
| isolate_o | output | 1 | Isolate request |
| col_test_o | output | 1 | Collision test enable |
| descr_test_o | output | 1 | Descrambler test mode |
| link_mon_test_o | output | 1 | Link monitor test mode |

## Verification
The assertions assume that bus and event inputs are synchronous to the clock and stable across each sampling edge. They also assume that reset is held for at least one edge before any access, so the past cycle of a response is always a bus sample. The bench drives every input on the falling edge. It holds strobe for one cycle per access and keeps the link input at 1 through reset, so the link-drop counter and the latch start from a known state. It also checks the cycle-low case and back-to-back access against an independent model.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;
  localparam int CNT_W   = 15;
  localparam int NUM_CNT = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] A_ID1  = 5'd2;
  localparam logic [ADDR_W-1:0] A_ID2  = 5'd3;
  localparam logic [ADDR_W-1:0] A_VND  = 5'd30;

  // counter slots: 0 neg wrap, 1 pos wrap, 2 link drop, 3 false carrier, 4 symbol error
  localparam logic [ADDR_W-1:0] CNT_ADDR [NUM_CNT] = '{5'd16, 5'd17, 5'd18, 5'd19, 5'd21};
  localparam int LINK_DROP_SLOT = 2;

  localparam logic [REG_W-1:0] CTRL_RST_VAL = 16'h2400;
  localparam logic [REG_W-1:0] STAT_FIXED   = 16'h6001;
  localparam int STAT_LINK_BIT = 2;

  function automatic logic is_cnt_addr(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (a == CNT_ADDR[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic is_impl_addr(input logic [ADDR_W-1:0] a);
    return (a == A_CTRL) || (a == A_STAT) || (a == A_ID1) || (a == A_ID2) ||
           (a == A_VND) || is_cnt_addr(a);
  endfunction

endpackage

// File: rtl/mgmt_ctrl_reg.sv
module mgmt_ctrl_reg
  import phy_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_vnd,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_val,
  output logic [REG_W-1:0] vnd_val,
  output logic             loopback_q,
  output logic             power_down_q,
  output logic             isolate_q,
  output logic             col_test_q,
  output logic             descr_test_q,
  output logic             link_mon_test_q
);

  logic duplex_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      loopback_q   <= CTRL_RST_VAL[14];
      power_down_q <= CTRL_RST_VAL[11];
      isolate_q    <= CTRL_RST_VAL[10];
      duplex_q     <= CTRL_RST_VAL[8];
      col_test_q   <= CTRL_RST_VAL[7];
    end else if (wr_ctrl) begin
      if (wdata[15]) begin
        loopback_q   <= CTRL_RST_VAL[14];
        power_down_q <= CTRL_RST_VAL[11];
        isolate_q    <= CTRL_RST_VAL[10];
        duplex_q     <= CTRL_RST_VAL[8];
        col_test_q   <= CTRL_RST_VAL[7];
      end else begin
        loopback_q   <= wdata[14];
        power_down_q <= wdata[11];
        isolate_q    <= wdata[10];
        duplex_q     <= wdata[8];
        col_test_q   <= wdata[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      descr_test_q    <= 1'b0;
      link_mon_test_q <= 1'b0;
    end else if (wr_vnd) begin
      descr_test_q    <= wdata[15];
      link_mon_test_q <= wdata[14];
    end
  end

  always_comb begin
    ctrl_val     = '0;
    ctrl_val[14] = loopback_q;
    ctrl_val[13] = 1'b1;
    ctrl_val[11] = power_down_q;
    ctrl_val[10] = isolate_q;
    ctrl_val[8]  = duplex_q;
    ctrl_val[7]  = col_test_q;
    vnd_val      = '0;
    vnd_val[15]  = descr_test_q;
    vnd_val[14]  = link_mon_test_q;
  end

  AST_CTRL_SELF_RESET: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[15]) |=> (isolate_q && !loopback_q && !power_down_q && !col_test_q)) // R3
    else $error("control reset bit did not restore defaults");

  AST_CTRL_WRITE_LOOPBACK: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wdata[15]) |=> (loopback_q == $past(wdata[14]))) // R2
    else $error("loopback output does not follow write");

endmodule

// File: rtl/mgmt_link_latch.sv
module mgmt_link_latch (
  input  logic clk,
  input  logic rst,
  input  logic link_up,
  input  logic rd_stat,
  output logic link_rd
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst)          held_q <= 1'b1;
    else if (rd_stat) held_q <= link_up;
    else              held_q <= held_q & link_up;
  end

  assign link_rd = held_q & link_up;

  AST_LINK_LATCH_LOW: assert property (@(posedge clk) disable iff (rst)
    (!link_up && !rd_stat) |=> !link_rd) // R5
    else $error("link drop not latched");

endmodule

// File: rtl/mgmt_event_ctr.sv
module mgmt_event_ctr #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             rd_clr,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] CMAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)                     count <= '0;
    else if (ld)                 count <= ld_val;
    else if (rd_clr)             count <= evt ? ONE : '0;
    else if (evt && count != CMAX) count <= count + ONE;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (count == CMAX && !ld && !rd_clr) |=> (count == CMAX)) // R7
    else $error("counter wrapped past maximum");

  AST_CNT_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !ld) |=> (count == (($past(evt)) ? ONE : '0))) // R8
    else $error("counter not cleared by read");

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  input  logic              link_up,
  input  logic              neg_wrap_evt,
  input  logic              pos_wrap_evt,
  input  logic              false_carrier_evt,
  input  logic              symbol_err_evt,
  output logic              loopback_o,
  output logic              power_down_o,
  output logic              isolate_o,
  output logic              col_test_o,
  output logic              descr_test_o,
  output logic              link_mon_test_o
);

  logic              access, impl_hit, do_rd, do_wr;
  logic [REG_W-1:0]  ctrl_val, vnd_val, rd_mux;
  logic              link_bit;
  logic              link_prev_q;
  logic              link_fall;
  logic [NUM_CNT-1:0] evt_vec;
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_sel;

  assign access   = bus_cyc && bus_stb;
  assign impl_hit = is_impl_addr(bus_addr);
  assign do_rd    = access && impl_hit && !bus_we;
  assign do_wr    = access && impl_hit && bus_we;

  // falling-edge detect for link-drop counter
  always_ff @(posedge clk) begin
    if (rst) link_prev_q <= 1'b0;
    else     link_prev_q <= link_up;
  end
  assign link_fall = link_prev_q && !link_up;

  assign evt_vec[0]              = neg_wrap_evt;
  assign evt_vec[1]              = pos_wrap_evt;
  assign evt_vec[LINK_DROP_SLOT] = link_fall;
  assign evt_vec[3]              = false_carrier_evt;
  assign evt_vec[4]              = symbol_err_evt;

  mgmt_ctrl_reg u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .wr_ctrl         (do_wr && bus_addr == A_CTRL),
    .wr_vnd          (do_wr && bus_addr == A_VND),
    .wdata           (bus_wdata),
    .ctrl_val        (ctrl_val),
    .vnd_val         (vnd_val),
    .loopback_q      (loopback_o),
    .power_down_q    (power_down_o),
    .isolate_q       (isolate_o),
    .col_test_q      (col_test_o),
    .descr_test_q    (descr_test_o),
    .link_mon_test_q (link_mon_test_o)
  );

  mgmt_link_latch u_link (
    .clk     (clk),
    .rst     (rst),
    .link_up (link_up),
    .rd_stat (do_rd && bus_addr == A_STAT),
    .link_rd (link_bit)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign cnt_sel[g] = (bus_addr == CNT_ADDR[g]);
    mgmt_event_ctr #(.WIDTH(CNT_W)) u_ctr (
      .clk    (clk),
      .rst    (rst),
      .evt    (evt_vec[g]),
      .ld     (do_wr && cnt_sel[g]),
      .ld_val (bus_wdata[CNT_W-1:0]),
      .rd_clr (do_rd && cnt_sel[g]),
      .count  (cnt_val[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CTRL) rd_mux = ctrl_val;
    if (bus_addr == A_VND)  rd_mux = vnd_val;
    if (bus_addr == A_STAT) begin
      rd_mux = STAT_FIXED;
      rd_mux[STAT_LINK_BIT] = link_bit;
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cnt_sel[i]) rd_mux = {{(REG_W-CNT_W){1'b0}}, cnt_val[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= access && impl_hit;
      bus_err   <= access && !impl_hit;
      bus_rdata <= do_rd ? rd_mux : '0;
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && bus_err)) // R11
    else $error("ack and err together");

  AST_RESP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bus_ack || bus_err) |-> $past(access)) // R11
    else $error("response without access");

  AST_ERR_ON_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (access && !impl_hit) |=> (bus_err && bus_rdata == '0)) // R6
    else $error("unmapped access not errored");

  AST_LINK_DROP_COUNT: assert property (@(posedge clk) disable iff (rst)
    (link_prev_q && !link_up) |-> evt_vec[LINK_DROP_SLOT]) // R9
    else $error("link fall not counted");

endmodule

// File: tb/phy_mgmt_regs_tb.sv
`timescale 1ns/1ps
module phy_mgmt_regs_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ack, err;
  logic link = 1'b1, nw = 1'b0, pw = 1'b0, fc = 1'b0, se = 1'b0;
  logic lb_o, pd_o, iso_o, ct_o, dt_o, lmt_o;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;

  always #4 clk = ~clk;

  phy_mgmt_regs dut_i (
    .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack),
    .bus_err(err), .link_up(link), .neg_wrap_evt(nw), .pos_wrap_evt(pw),
    .false_carrier_evt(fc), .symbol_err_evt(se), .loopback_o(lb_o),
    .power_down_o(pd_o), .isolate_o(iso_o), .col_test_o(ct_o),
    .descr_test_o(dt_o), .link_mon_test_o(lmt_o)
  );

  // ---------------- behavioural reference model ----------------
  int m_ctrl, m_vnd, m_rd, m_prev_addr;
  bit m_ack, m_err, m_lst, m_prev;
  int m_cnt [5];
  int cnt_addrs [5] = '{16, 17, 18, 19, 21};

  function automatic bit impl(int a);
    return a == 0 || a == 1 || a == 2 || a == 3 || a == 16 || a == 17 ||
           a == 18 || a == 19 || a == 21 || a == 30;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 'h2400; m_vnd = 0; m_rd = 0; m_ack = 0; m_err = 0;
      m_lst = 1; m_prev = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      bit acc, ok, fall;
      bit ev [5];
      acc = cyc && stb;
      ok  = impl(addr);
      m_ack = acc && ok;
      m_err = acc && !ok;
      m_rd  = 0;
      m_prev_addr = addr;
      fall = m_prev && !link;
      m_prev = link;
      ev[0] = nw; ev[1] = pw; ev[2] = fall; ev[3] = fc; ev[4] = se;
      if (acc && ok && !we) begin
        case (addr)
          0: m_rd = m_ctrl;
          1: m_rd = 'h6001 | ((m_lst && link) ? 4 : 0);
          30: m_rd = m_vnd;
          default: m_rd = 0;
        endcase
        foreach (cnt_addrs[i]) if (addr == cnt_addrs[i]) m_rd = m_cnt[i];
      end
      if (acc && ok && !we && addr == 1) m_lst = link;
      else m_lst = m_lst && link;
      foreach (cnt_addrs[i]) begin
        if (acc && ok && we && addr == cnt_addrs[i]) m_cnt[i] = wdata & 'h7fff;
        else if (acc && ok && !we && addr == cnt_addrs[i]) m_cnt[i] = ev[i] ? 1 : 0;
        else if (ev[i] && m_cnt[i] < 'h7fff) m_cnt[i]++;
      end
      if (acc && ok && we && addr == 0)
        m_ctrl = wdata[15] ? 'h2400 : ('h2000 | (wdata & 'h4d80));
      if (acc && ok && we && addr == 30) m_vnd = wdata & 'hc000;
    end
  end

  function automatic string req_of(int a);
    if (a == 0) return "R1";
    if (a == 1) return "R5";
    if (a == 2 || a == 3) return "R4";
    if (a == 30) return "R10";
    return "R8";
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cyc_cnt++;
      chk("R11", "ack", ack, m_ack);
      chk("R6",  "err", err, m_err);
      chk(req_of(m_prev_addr), "rdata", rdata, m_rd);
      chk("R2", "loopback", lb_o, (m_ctrl >> 14) & 1);
      chk("R2", "power_down", pd_o, (m_ctrl >> 11) & 1);
      chk("R2", "isolate", iso_o, (m_ctrl >> 10) & 1);
      chk("R2", "col_test", ct_o, (m_ctrl >> 7) & 1);
      chk("R10", "descr_test", dt_o, (m_vnd >> 15) & 1);
      chk("R10", "link_mon_test", lmt_o, (m_vnd >> 14) & 1);
    end
  end

  // ---------------- directed accesses ----------------
  logic [15:0] r_data;
  logic r_ack, r_err;

  task automatic xfer(input int a, input bit w, input int d);
    cyc = 1; stb = 1; we = w; addr = a[4:0]; wdata = d[15:0];
    @(negedge clk);
    r_data = rdata; r_ack = ack; r_err = err;
    stb = 0; we = 0; wdata = '0;
  endtask

  task automatic rd_chk(int a, int exp, string req);
    xfer(a, 0, 0);
    chk(req, $sformatf("read addr %0d", a), r_data, exp);
    chk("R11", "read ack", r_ack, 1);
  endtask

  task automatic wr(int a, int d);
    xfer(a, 1, d);
    chk("R11", "write ack", r_ack, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset isolate output", iso_o, 1);
    rd_chk(0, 'h2400, "R1");
    wr(0, 'h0000);  rd_chk(0, 'h2000, "R1");
    wr(0, 'h4000);  chk("R2", "loopback on", lb_o, 1); rd_chk(0, 'h6000, "R2");
    wr(0, 'h0800);  chk("R2", "power down on", pd_o, 1); rd_chk(0, 'h2800, "R2");
    wr(0, 'h0180);  chk("R2", "col test on", ct_o, 1); rd_chk(0, 'h2180, "R2");
    wr(0, 'h3e7f);  rd_chk(0, 'h2c00, "R2");
    wr(0, 'hcd80);  rd_chk(0, 'h2400, "R3");
    chk("R3", "loopback after reset bit", lb_o, 0);
    wr(1, 'hffff);  rd_chk(1, 'h6005, "R4");
    wr(2, 'hffff);  rd_chk(2, 0, "R4");
    wr(3, 'hffff);  rd_chk(3, 0, "R4");
    // latch low
    link = 0; idle(2); link = 1; idle(1);
    rd_chk(1, 'h6001, "R5");
    rd_chk(1, 'h6005, "R5");
    link = 0; idle(1);
    rd_chk(1, 'h6001, "R5");
    link = 1; idle(1);
    rd_chk(1, 'h6001, "R5");
    rd_chk(1, 'h6005, "R5");
    // unimplemented
    xfer(15, 0, 0); chk("R6", "err on read 15", r_err, 1); chk("R6", "no ack 15", r_ack, 0);
    xfer(31, 1, 'hffff); chk("R6", "err on write 31", r_err, 1);
    rd_chk(0, 'h2400, "R6");
    // no response without cyc
    cyc = 0; stb = 1; addr = 0; @(negedge clk);
    chk("R11", "no ack without cyc", ack, 0); stb = 0; cyc = 1;
    // counters: clear link-drop counter first
    rd_chk(18, 2, "R9");
    nw = 1; idle(4); nw = 0;
    rd_chk(16, 4, "R9");
    rd_chk(16, 0, "R8");
    wr(17, 'hfffd); pw = 1; idle(6); pw = 0;
    rd_chk(17, 'h7fff, "R7");
    rd_chk(17, 0, "R8");
    fc = 1; rd_chk(19, 0, "R8"); fc = 0;
    rd_chk(19, 1, "R8");
    se = 1; idle(3); se = 0; rd_chk(21, 3, "R9");
    link = 0; idle(3); link = 1; idle(2); link = 0; idle(1); link = 1; idle(1);
    rd_chk(18, 2, "R9");
    rd_chk(1, 'h6001, "R5");
    // vendor
    wr(30, 'h8000); chk("R10", "descr test on", dt_o, 1); rd_chk(30, 'h8000, "R10");
    wr(30, 'h7fff); chk("R10", "link mon test on", lmt_o, 1); rd_chk(30, 'h4000, "R10");
    wr(30, 0);      rd_chk(30, 0, "R10");
    // back-to-back accesses
    stb = 1; we = 0; addr = 0; @(negedge clk); addr = 1; @(negedge clk); stb = 0;
    chk("R11", "second back-to-back ack", ack, 1);
    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual %0d expected 0", cyc_cnt);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule